// File: doc/BRIEF.md
# Multi-Mode Operand Addressing Unit

This unit carries out one register-accumulate add, `reg[dst] = reg[dst] + operand`, where the operand is fetched under one of ten addressing modes. It holds an eight-entry, 32-bit register file. It reaches a word memory through a read port with a request/valid handshake.

A caller presents the mode, three register numbers (destination, base, index) and a 32-bit constant, and pulses `start`. The unit forms the effective address from the register file, then performs zero, one or two memory reads. Two reads occur only in the double-fetch mode, where the first read yields the address of the second. In the stepping modes it also moves the base register by one element (4 bytes). At the end it writes the sum back, pulses `done` for one cycle, and shows the written value on `result` in that cycle.

Reading a register is done with an immediate add of zero: the `result` of that operation is the register's current value.

Top module: `opnd_addr_unit`

## Requirements
- R1: A synchronous reset clears all eight registers to zero and leaves `busy`, `done` and `mem_req` low.
- R2: Mode 0 adds the register named by `base_sel`. Mode 1 adds `imm`. Neither mode issues any memory request.
- R3: Four modes make one read and add the word read. The read address is `imm + reg[base]` in mode 2, `reg[base]` in mode 3, `reg[base] + reg[idx]` in mode 4, and `imm` in mode 5.
- R4: Mode 6 reads at `reg[base]`, then reads again at the word returned, and adds the second word.
- R5: Modes 7 and 8 read at the old `reg[base]` and add that word. In the same write-back cycle, `reg[base]` becomes the old value plus 4 (mode 7) or minus 4 (mode 8).
- R6: Mode 9 reads at `imm + reg[base] + (reg[idx] << 2)` and adds the word read.
- R7: In mode 7 or 8 with `base_sel == dst_sel`, the register holds the accumulate sum afterwards, and the step is lost.
- R8: `busy` is high from the cycle after `start` is taken through the `done` cycle. `done` lasts exactly one cycle, and `result` then equals the value written to `reg[dst]`.
- R9: `start` is ignored while `busy` is high; no register changes because of it.
- R10: While `mem_req` is high and `mem_vld` is low, `mem_req` stays high and `mem_addr` stays unchanged in the next cycle.
- R11: Mode codes 10 to 15 behave as mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (taken when idle) |
| mode | input | 4 | Addressing mode code |
| dst_sel | input | 3 | Destination register number |
| base_sel | input | 3 | Base / second source register number |
| idx_sel | input | 3 | Index register number |
| imm | input | 32 | Immediate, displacement or absolute address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_vld | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Value written to the destination during `done` |

## Verification
In the stepping modes, the accumulate write and the base-register step fall in the same write-back cycle. Both target one register file, and they collide when the base and destination numbers are equal. The bench provokes the collision with modes 7 and 8 using the same register number in both fields. It judges the outcome by reading the register back with an immediate add of zero, and expects the accumulate sum, not the stepped address. It also runs the non-colliding case, where both writes must land.

// File: rtl/oau_pkg.sv
package oau_pkg;

    typedef enum logic [3:0] {
        AM_REG    = 4'd0,
        AM_IMM    = 4'd1,
        AM_DISP   = 4'd2,
        AM_RIND   = 4'd3,
        AM_INDEX  = 4'd4,
        AM_ABS    = 4'd5,
        AM_MIND   = 4'd6,
        AM_AINC   = 4'd7,
        AM_ADEC   = 4'd8,
        AM_SCALED = 4'd9
    } oau_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_READ1 = 3'd2,
        ST_READ2 = 3'd3,
        ST_WB    = 3'd4
    } oau_state_e;

    // access class of a mode, produced by the address generator
    typedef struct packed {
        logic mem;   // needs at least one read
        logic ind;   // needs a second, dependent read
        logic inc;   // base steps up
        logic dec;   // base steps down
    } oau_acc_t;

endpackage

// File: rtl/oau_regfile.sv
module oau_regfile
    import oau_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NREGS = 8,
    localparam int RW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [RW-1:0] rb_addr,
    output logic [DW-1:0] rb_data,
    input  logic [RW-1:0] rc_addr,
    output logic [DW-1:0] rc_data,
    // accumulate write port (higher priority)
    input  logic          wa_en,
    input  logic [RW-1:0] wa_addr,
    input  logic [DW-1:0] wa_data,
    // base-step write port
    input  logic          wb_en,
    input  logic [RW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data
);

    logic [DW-1:0] rf_d [NREGS];
    logic [DW-1:0] rf_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            rf_d[i] = rf_q[i];
            if (wb_en && (wb_addr == RW'(i))) rf_d[i] = wb_data;
            if (wa_en && (wa_addr == RW'(i))) rf_d[i] = wa_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) rf_q[i] <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign ra_data = rf_q[ra_addr];
    assign rb_data = rf_q[rb_addr];
    assign rc_data = rf_q[rc_addr];

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rf_q[0] == '0) && (rf_q[NREGS-1] == '0));

    // R7
    acc_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wa_en && wb_en && (wa_addr == wb_addr)) |=> (rf_q[$past(wa_addr)] == $past(wa_data)));

endmodule

// File: rtl/oau_agen.sv
module oau_agen
    import oau_pkg::*;
#(
    parameter int DW       = 32,
    parameter int SCALE_SH = 2
) (
    input  oau_mode_e     mode,
    input  logic [DW-1:0] base_v,
    input  logic [DW-1:0] idx_v,
    input  logic [DW-1:0] imm,
    output logic [DW-1:0] addr,
    output oau_acc_t      acc
);

    always_comb begin
        addr = base_v;
        acc  = '0;
        case (mode)
            AM_DISP: begin
                addr    = imm + base_v;
                acc.mem = 1'b1;
            end
            AM_RIND: begin
                acc.mem = 1'b1;
            end
            AM_INDEX: begin
                addr    = base_v + idx_v;
                acc.mem = 1'b1;
            end
            AM_ABS: begin
                addr    = imm;
                acc.mem = 1'b1;
            end
            AM_MIND: begin
                acc.mem = 1'b1;
                acc.ind = 1'b1;
            end
            AM_AINC: begin
                acc.mem = 1'b1;
                acc.inc = 1'b1;
            end
            AM_ADEC: begin
                acc.mem = 1'b1;
                acc.dec = 1'b1;
            end
            AM_SCALED: begin
                addr    = imm + base_v + (idx_v << SCALE_SH);
                acc.mem = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/oau_ctrl.sv
module oau_ctrl
    import oau_pkg::*;
#(
    parameter int DW       = 32,
    parameter int NREGS    = 8,
    parameter int SCALE_SH = 2,
    localparam int RW      = $clog2(NREGS),
    localparam logic [DW-1:0] STEP = DW'(1) << SCALE_SH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [3:0]    mode_i,
    input  logic [RW-1:0] dst_i,
    input  logic [RW-1:0] base_i,
    input  logic [RW-1:0] idx_i,
    input  logic [DW-1:0] imm_i,
    // latched fields toward register file and address generator
    output logic [RW-1:0] dst_q_o,
    output logic [RW-1:0] base_q_o,
    output logic [RW-1:0] idx_q_o,
    output oau_mode_e     mode_q_o,
    output logic [DW-1:0] imm_q_o,
    input  logic [DW-1:0] dst_v,
    input  logic [DW-1:0] base_v,
    input  logic [DW-1:0] ag_addr,
    input  oau_acc_t      ag_acc,
    // memory
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic          mem_vld,
    input  logic [DW-1:0] mem_rdata,
    // register writes
    output logic          wa_en,
    output logic [DW-1:0] wa_data,
    output logic          wb_en,
    output logic [DW-1:0] wb_data,
    // status
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] result
);

    typedef struct packed {
        oau_state_e    st;
        oau_mode_e     mode;
        logic [RW-1:0] dst;
        logic [RW-1:0] base;
        logic [RW-1:0] idx;
        logic [DW-1:0] imm;
        logic [DW-1:0] addr;
        logic [DW-1:0] opnd;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d   = ctl_q;
        mem_req = 1'b0;
        done    = 1'b0;
        wa_en   = 1'b0;
        wb_en   = 1'b0;
        wa_data = dst_v + ctl_q.opnd;
        wb_data = ag_acc.dec ? (base_v - STEP) : (base_v + STEP);
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st   = ST_ADDR;
                    ctl_d.mode = oau_mode_e'(mode_i);
                    ctl_d.dst  = dst_i;
                    ctl_d.base = base_i;
                    ctl_d.idx  = idx_i;
                    ctl_d.imm  = imm_i;
                end
            end
            ST_ADDR: begin
                ctl_d.addr = ag_addr;
                ctl_d.opnd = (ctl_q.mode == AM_REG) ? base_v : ctl_q.imm;
                ctl_d.st   = ag_acc.mem ? ST_READ1 : ST_WB;
            end
            ST_READ1: begin
                mem_req = 1'b1;
                if (mem_vld) begin
                    if (ag_acc.ind) begin
                        ctl_d.addr = mem_rdata;
                        ctl_d.st   = ST_READ2;
                    end else begin
                        ctl_d.opnd = mem_rdata;
                        ctl_d.st   = ST_WB;
                    end
                end
            end
            ST_READ2: begin
                mem_req = 1'b1;
                if (mem_vld) begin
                    ctl_d.opnd = mem_rdata;
                    ctl_d.st   = ST_WB;
                end
            end
            ST_WB: begin
                done     = 1'b1;
                wa_en    = 1'b1;
                wb_en    = ag_acc.inc | ag_acc.dec;
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        result = done ? wa_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign busy     = (ctl_q.st != ST_IDLE);
    assign mem_addr = ctl_q.addr;
    assign dst_q_o  = ctl_q.dst;
    assign base_q_o = ctl_q.base;
    assign idx_q_o  = ctl_q.idx;
    assign mode_q_o = ctl_q.mode;
    assign imm_q_o  = ctl_q.imm;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    // R4
    second_read_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_READ2) |-> (ctl_q.mode == AM_MIND));

    // R9
    fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ctl_q.dst) && $stable(ctl_q.mode) && $stable(ctl_q.imm));

endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
    import oau_pkg::*;
#(
    parameter int DW       = 32,
    parameter int NREGS    = 8,
    parameter int SCALE_SH = 2,
    localparam int RW      = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [RW-1:0] dst_sel,
    input  logic [RW-1:0] base_sel,
    input  logic [RW-1:0] idx_sel,
    input  logic [DW-1:0] imm,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic          mem_vld,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] result
);

    logic [RW-1:0] dst_q, base_q, idx_q;
    oau_mode_e     mode_q;
    logic [DW-1:0] imm_q;
    logic [DW-1:0] dst_v, base_v, idx_v;
    logic [DW-1:0] ag_addr;
    oau_acc_t      ag_acc;
    logic          wa_en, wb_en;
    logic [DW-1:0] wa_data, wb_data;

    oau_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_addr (dst_q),
        .ra_data (dst_v),
        .rb_addr (base_q),
        .rb_data (base_v),
        .rc_addr (idx_q),
        .rc_data (idx_v),
        .wa_en   (wa_en),
        .wa_addr (dst_q),
        .wa_data (wa_data),
        .wb_en   (wb_en),
        .wb_addr (base_q),
        .wb_data (wb_data)
    );

    oau_agen #(.DW(DW), .SCALE_SH(SCALE_SH)) u_agen (
        .mode   (mode_q),
        .base_v (base_v),
        .idx_v  (idx_v),
        .imm    (imm_q),
        .addr   (ag_addr),
        .acc    (ag_acc)
    );

    oau_ctrl #(.DW(DW), .NREGS(NREGS), .SCALE_SH(SCALE_SH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode_i    (mode),
        .dst_i     (dst_sel),
        .base_i    (base_sel),
        .idx_i     (idx_sel),
        .imm_i     (imm),
        .dst_q_o   (dst_q),
        .base_q_o  (base_q),
        .idx_q_o   (idx_q),
        .mode_q_o  (mode_q),
        .imm_q_o   (imm_q),
        .dst_v     (dst_v),
        .base_v    (base_v),
        .ag_addr   (ag_addr),
        .ag_acc    (ag_acc),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_vld   (mem_vld),
        .mem_rdata (mem_rdata),
        .wa_en     (wa_en),
        .wa_data   (wa_data),
        .wb_en     (wb_en),
        .wb_data   (wb_data),
        .busy      (busy),
        .done      (done),
        .result    (result)
    );

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_vld) |=> mem_req && $stable(mem_addr));

    // R2
    no_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mode_q != AM_REG) && (mode_q != AM_IMM));

endmodule

// File: tb/opnd_addr_unit_bench.sv
`timescale 1ns/1ps
module opnd_addr_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [2:0]  dst_sel = '0, base_sel = '0, idx_sel = '0;
    logic [31:0] imm = '0;
    logic        mem_req, busy, done;
    logic [31:0] mem_addr, result;
    logic        mem_vld;
    logic [31:0] mem_rdata;

    int total = 0, bad = 0;
    int hold_tot = 0, hold_bad = 0;
    int rcnt = 0;
    logic [31:0] alog [4];
    logic        prev_wait;
    logic [31:0] prev_addr;
    logic [31:0] m [8];

    always #10 clk = ~clk;

    opnd_addr_unit u_opnd_addr_unit (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .dst_sel(dst_sel), .base_sel(base_sel), .idx_sel(idx_sel), .imm(imm),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_vld(mem_vld),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .result(result)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'd2654435761) ^ 32'h5A5A_0F0F;
    endfunction

    // memory: answers one cycle after each new request; checks R10 hold
    always @(posedge clk) begin
        if (rst) begin
            mem_vld   <= 1'b0;
            prev_wait <= 1'b0;
            rcnt      <= 0;
        end else begin
            if (prev_wait) begin
                hold_tot <= hold_tot + 1;
                if (!(mem_req && mem_addr == prev_addr)) begin
                    hold_bad <= hold_bad + 1;
                    $display("FAIL R10 req/addr act=%b/%h exp=1/%h", mem_req, mem_addr, prev_addr);
                end
            end
            if (mem_req && !mem_vld) begin
                alog[rcnt % 4] <= mem_addr;
                rcnt <= rcnt + 1;
            end
            prev_wait <= mem_req && !mem_vld;
            prev_addr <= mem_addr;
            mem_vld   <= mem_req && !mem_vld;
        end
        mem_rdata <= memf(mem_addr);
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int md);
        case (md)
            0, 1:       return "R2";
            2, 3, 4, 5: return "R3";
            6:          return "R4";
            7, 8:       return "R5";
            9:          return "R6";
            default:    return "R11";
        endcase
    endfunction

    task automatic run_op(input logic [3:0] md, input logic [2:0] d, input logic [2:0] b,
                          input logic [2:0] x, input logic [31:0] k, input bit ghost,
                          input string tag);
        logic [31:0] a1, a2, opnd, exp_res;
        int nrd, c0, md_i;
        bit seen;
        md_i = int'(md);
        a1 = '0; a2 = '0; nrd = 1;
        case (md_i)
            0: begin opnd = m[b]; nrd = 0; end
            2: a1 = k + m[b];
            3, 7, 8: a1 = m[b];
            4: a1 = m[b] + m[x];
            5: a1 = k;
            6: begin a1 = m[b]; a2 = memf(a1); nrd = 2; end
            9: a1 = k + m[b] + (m[x] << 2);
            default: begin opnd = k; nrd = 0; end
        endcase
        if (nrd == 1) opnd = memf(a1);
        if (nrd == 2) opnd = memf(a2);
        exp_res = m[d] + opnd;
        c0 = rcnt;
        @(negedge clk);
        start = 1'b1; mode = md; dst_sel = d; base_sel = b; idx_sel = x; imm = k;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R8 busy after start", 32'(busy), 32'd1);
        if (ghost) begin
            start = 1'b1; mode = 4'd1; dst_sel = 3'd6; imm = 32'h0000_0999;
            @(negedge clk);
            start = 1'b0;
        end
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (done === 1'b1) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        chk(seen, {tag, " done seen"}, 32'(seen), 32'd1);
        chk(result === exp_res, {tag, " result"}, result, exp_res);
        chk((rcnt - c0) == nrd, {tag, " read count"}, 32'(rcnt - c0), 32'(nrd));
        if (nrd >= 1) chk(alog[c0 % 4] === a1, {tag, " first address"}, alog[c0 % 4], a1);
        if (nrd == 2) chk(alog[(c0 + 1) % 4] === a2, {tag, " second address"}, alog[(c0 + 1) % 4], a2);
        if (md_i == 7) m[b] = m[b] + 32'd4;
        if (md_i == 8) m[b] = m[b] - 32'd4;
        m[d] = exp_res;
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R8 single done", {30'd0, done, busy}, 32'd0);
    endtask

    // {mode, dst, base, idx, imm}
    localparam logic [44:0] VEC [14] = '{
        {4'd1, 3'd1, 3'd0, 3'd0, 32'h0000_0100},
        {4'd1, 3'd2, 3'd0, 3'd0, 32'h0000_0020},
        {4'd1, 3'd3, 3'd0, 3'd0, 32'h0000_0003},
        {4'd0, 3'd4, 3'd1, 3'd0, 32'h0000_0000},
        {4'd2, 3'd5, 3'd1, 3'd0, 32'h0000_0010},
        {4'd3, 3'd5, 3'd2, 3'd0, 32'h0000_0000},
        {4'd4, 3'd6, 3'd1, 3'd2, 32'h0000_0000},
        {4'd5, 3'd6, 3'd0, 3'd0, 32'h0000_0400},
        {4'd6, 3'd7, 3'd2, 3'd0, 32'h0000_0000},
        {4'd7, 3'd4, 3'd1, 3'd0, 32'h0000_0000},
        {4'd8, 3'd4, 3'd2, 3'd0, 32'h0000_0000},
        {4'd9, 3'd5, 3'd1, 3'd3, 32'h0000_0008},
        {4'd12, 3'd3, 3'd1, 3'd2, 32'h0000_0005},
        {4'd15, 3'd0, 3'd0, 3'd0, 32'hFFFF_FFFF}
    };

    initial begin
        for (int i = 0; i < 8; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle outputs after reset
        chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R1 idle after reset",
            {29'd0, busy, done, mem_req}, 32'd0);

        for (int i = 0; i < 14; i++) begin
            run_op(VEC[i][44:41], VEC[i][40:38], VEC[i][37:35], VEC[i][34:32], VEC[i][31:0],
                   1'b0, tag_of(int'(VEC[i][44:41])));
        end

        // R7: base equals destination in stepping modes; sum must win
        run_op(4'd7, 3'd3, 3'd3, 3'd0, 32'd0, 1'b0, "R7 inc");
        run_op(4'd1, 3'd3, 3'd0, 3'd0, 32'd0, 1'b0, "R7 readback inc");
        run_op(4'd8, 3'd2, 3'd2, 3'd0, 32'd0, 1'b0, "R7 dec");
        run_op(4'd1, 3'd2, 3'd0, 3'd0, 32'd0, 1'b0, "R7 readback dec");

        // R5: base update lands when base differs from destination
        run_op(4'd7, 3'd6, 3'd1, 3'd0, 32'd0, 1'b0, "R5 inc");
        run_op(4'd1, 3'd1, 3'd0, 3'd0, 32'd0, 1'b0, "R5 readback base");

        // R9: start while busy is ignored
        run_op(4'd7, 3'd4, 3'd1, 3'd0, 32'd0, 1'b1, "R9 busy op");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(busy === 1'b0, "R9 no restart", 32'(busy), 32'd0);
        end
        run_op(4'd1, 3'd6, 3'd0, 3'd0, 32'd0, 1'b0, "R9 readback r6");

        // R1: reset mid-run clears every register
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) m[i] = '0;
        chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R1 idle after second reset",
            {29'd0, busy, done, mem_req}, 32'd0);
        for (int r = 0; r < 8; r++) begin
            run_op(4'd1, 3'(r), 3'd0, 3'd0, 32'd0, 1'b0, "R1 cleared register");
        end

        // R10: hold checks counted by the memory model
        total += hold_tot;
        bad   += hold_bad;
        chk(hold_tot > 0, "R10 hold observed", 32'(hold_tot), 32'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

endmodule